// File: doc/BRIEF.md
# USB Bus Reset Detector

This block watches the upstream D+ and D− line levels, which arrive already aligned to the 12 MHz device clock, and decides when the host is signalling a bus reset. A bus reset is a single-ended zero (both lines low) held long enough. The block requires a fixed run of consecutive SE0 samples. The default run is 168 cycles, or 14 µs, which lies inside the 12 to 16 µs window where recognition is allowed.

When the run completes, the block does four things. It sets a sticky status bit that firmware clears by writing zero. It emits a one-cycle strobe that clears the device-address and hub-port registers. If the power-on start-up delay is still running, it emits a one-cycle abort with that strobe. When SE0 is finally released, it emits a one-cycle interrupt. Any sample that is not SE0 restarts the count. An SE0 that ends before the threshold is reached leaves no trace.

Top module: `usb_bus_reset_det`

## Requirements
- R1: SE0 means both synchronized lines are low. A state with exactly one line low, held for any length, never leads to recognition.
- R2: Each line passes through SYNC_STAGES flops. For raw SE0 applied before clock edge 1, `regs_clr` is high right after edge THRESH+SYNC_STAGES, which happens when THRESH consecutive SE0 samples have been seen.
- R3: A run of THRESH−1 SE0 samples is not recognized. A single non-SE0 sample restarts the count, so two runs of THRESH−1 split by one such sample produce no recognition.
- R4: `regs_clr` is a one-cycle pulse, issued once per reset event however long SE0 persists.
- R5: `rst_seen` goes high in the same cycle as `regs_clr`. It stays high until a cycle with `status_clr` high, after which it reads 0.
- R6: `irq` is a one-cycle pulse. It goes high one cycle after the synchronized SE0 ends, that is, right after edge L+SYNC_STAGES+1 for raw SE0 held over edges 1..L, and only when recognition happened.
- R7: An SE0 that ends before recognition produces no `irq`.
- R8: `startup_abort` pulses in the same cycle as `regs_clr` when `startup_active` is high at recognition, and stays 0 otherwise.
- R9: After reset, `rst_seen`, `regs_clr`, `irq` and `startup_abort` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 12 MHz device clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dp_line | input | 1 | Upstream D+ level |
| dm_line | input | 1 | Upstream D− level |
| startup_active | input | 1 | High while the power-on start-up delay runs |
| status_clr | input | 1 | Firmware write of zero to the status bit |
| rst_seen | output | 1 | Sticky bus-reset status |
| regs_clr | output | 1 | One-cycle clear for address and hub-port registers |
| irq | output | 1 | One-cycle interrupt at SE0 release |
| startup_abort | output | 1 | One-cycle abort of the start-up delay |

## Verification
The bench builds the detector with THRESH=12 and SYNC_STAGES=2. With these values, the exact threshold, the run one sample short of it, a broken run and an SE0 four times the threshold all fit in a few dozen cycles. Each of them can be timed to the exact cycle. Because the synchronizer depth is the default, the release-to-interrupt latency the bench expects is the same one the production build has.

// File: rtl/usb_bus_reset_det.sv
module usb_bus_reset_det #(
  parameter int THRESH      = 168,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dp_line,
  input  logic dm_line,
  input  logic startup_active,
  input  logic status_clr,
  output logic rst_seen,
  output logic regs_clr,
  output logic irq,
  output logic startup_abort
);

  localparam int CW = $clog2(THRESH + 1);

  logic [SYNC_STAGES-1:0] dp_sh, dm_sh;
  logic [CW-1:0]          run_cnt;
  logic                   armed;
  logic                   se0, hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dp_sh <= '1;
      dm_sh <= '0;
    end else begin
      dp_sh <= {dp_sh[SYNC_STAGES-2:0], dp_line};
      dm_sh <= {dm_sh[SYNC_STAGES-2:0], dm_line};
    end
  end

  assign se0 = ~dp_sh[SYNC_STAGES-1] & ~dm_sh[SYNC_STAGES-1];
  assign hit = se0 && (run_cnt == CW'(THRESH - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      run_cnt <= '0;
    else if (!se0)
      run_cnt <= '0;
    else if (run_cnt != CW'(THRESH))
      run_cnt <= run_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed         <= 1'b0;
      regs_clr      <= 1'b0;
      irq           <= 1'b0;
      startup_abort <= 1'b0;
      rst_seen      <= 1'b0;
    end else begin
      regs_clr      <= hit;
      startup_abort <= hit & startup_active;
      irq           <= armed & ~se0;
      if (hit)
        armed <= 1'b1;
      else if (!se0)
        armed <= 1'b0;
      if (hit)
        rst_seen <= 1'b1;
      else if (status_clr)
        rst_seen <= 1'b0;
    end
  end

  a_r4_clr_single: assert property (@(posedge clk) disable iff (!rst_n)
    regs_clr |=> !regs_clr);
  a_r5_status_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_seen) |-> regs_clr);
  a_r5_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_seen && !status_clr) |=> rst_seen);
  a_r6_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  a_r6_irq_not_with_clr: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !regs_clr);
  a_r8_abort_with_clr: assert property (@(posedge clk) disable iff (!rst_n)
    startup_abort |-> regs_clr);
  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt <= CW'(THRESH));

endmodule

// File: tb/usb_bus_reset_det_tb.sv
module usb_bus_reset_det_tb;
  localparam int TH = 12;
  localparam int SS = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic dp = 1'b1, dm = 1'b0, st_act = 1'b0, st_clr = 1'b0;
  logic rst_seen, regs_clr, irq, startup_abort;
  int checks = 0, failures = 0;
  int n_clr = 0, n_irq = 0, n_abort = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  usb_bus_reset_det #(.THRESH(TH), .SYNC_STAGES(SS)) u_dut (
    .clk(clk), .rst_n(rst_n), .dp_line(dp), .dm_line(dm),
    .startup_active(st_act), .status_clr(st_clr),
    .rst_seen(rst_seen), .regs_clr(regs_clr), .irq(irq),
    .startup_abort(startup_abort));

  always @(negedge clk) begin
    if (regs_clr) n_clr++;
    if (irq) n_irq++;
    if (startup_abort) n_abort++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic zero_counts();
    n_clr = 0; n_irq = 0; n_abort = 0;
  endtask

  task automatic burst(input int len, input int tail, output int clr_at, output int irq_at, output int ab_at);
    clr_at = -1; irq_at = -1; ab_at = -1;
    dp = 1'b0; dm = 1'b0;
    for (int k = 1; k <= len + tail; k++) begin
      @(posedge clk); @(negedge clk);
      if (regs_clr && clr_at < 0) clr_at = k;
      if (irq && irq_at < 0) irq_at = k;
      if (startup_abort && ab_at < 0) ab_at = k;
      if (k == len) begin dp = 1'b1; dm = 1'b0; end
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clear_status();
    st_clr = 1'b1; @(negedge clk); st_clr = 1'b0;
  endtask

  task automatic t_reset();
    chk(rst_seen == 0, "R9 rst_seen", rst_seen, 0);
    chk(regs_clr == 0 && irq == 0 && startup_abort == 0, "R9 pulses",
        {regs_clr, irq, startup_abort}, 0);
  endtask

  task automatic t_exact();
    int c, i, a;
    zero_counts();
    burst(TH, 8, c, i, a);
    chk(c == TH + SS, "R2 clr timing", c, TH + SS);
    chk(n_clr == 1, "R4 clr count", n_clr, 1);
    chk(rst_seen == 1, "R5 status set", rst_seen, 1);
    chk(i == TH + SS + 1, "R6 irq timing", i, TH + SS + 1);
    chk(n_irq == 1, "R6 irq count", n_irq, 1);
    chk(n_abort == 0, "R8 no abort", n_abort, 0);
  endtask

  task automatic t_status();
    wait_n(30);
    chk(rst_seen == 1, "R5 status sticky", rst_seen, 1);
    clear_status();
    chk(rst_seen == 0, "R5 status cleared", rst_seen, 1'b0);
  endtask

  task automatic t_short();
    int c, i, a;
    zero_counts();
    burst(TH - 1, 8, c, i, a);
    chk(n_clr == 0, "R3 short not recognized", n_clr, 0);
    chk(n_irq == 0, "R7 no irq on short", n_irq, 0);
    chk(rst_seen == 0, "R3 status stays low", rst_seen, 0);
  endtask

  task automatic t_broken();
    zero_counts();
    dp = 1'b0; dm = 1'b0; wait_n(TH - 1);
    dp = 1'b0; dm = 1'b1; wait_n(1);
    dp = 1'b0; dm = 1'b0; wait_n(TH - 1);
    dp = 1'b1; dm = 1'b0; wait_n(8);
    chk(n_clr == 0, "R3 broken run", n_clr, 0);
    chk(n_irq == 0, "R7 broken run irq", n_irq, 0);
  endtask

  task automatic t_one_low();
    zero_counts();
    dp = 1'b0; dm = 1'b1; wait_n(3 * TH);
    dp = 1'b1; dm = 1'b0; wait_n(3 * TH);
    dp = 1'b1; dm = 1'b1; wait_n(3 * TH);
    dp = 1'b1; dm = 1'b0; wait_n(4);
    chk(n_clr == 0, "R1 single line low", n_clr, 0);
    chk(rst_seen == 0, "R1 status low", rst_seen, 0);
  endtask

  task automatic t_long();
    int c, i, a;
    zero_counts();
    burst(4 * TH, 8, c, i, a);
    chk(n_clr == 1, "R4 one clr on long SE0", n_clr, 1);
    chk(c == TH + SS, "R2 clr timing long", c, TH + SS);
    chk(i == 4 * TH + SS + 1, "R6 irq at release", i, 4 * TH + SS + 1);
    chk(n_irq == 1, "R6 irq count long", n_irq, 1);
    clear_status();
  endtask

  task automatic t_abort();
    int c, i, a;
    zero_counts();
    st_act = 1'b1;
    burst(TH + 3, 6, c, i, a);
    st_act = 1'b0;
    chk(a == c && a == TH + SS, "R8 abort with clr", a, TH + SS);
    chk(n_abort == 1, "R8 abort count", n_abort, 1);
    clear_status();
  endtask

  initial begin
    #200000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    wait_n(3);
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    wait_n(4);
    t_reset();
    t_exact();
    t_status();
    t_short();
    t_broken();
    t_one_low();
    t_long();
    t_abort();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule